// File: doc/BRIEF.md
# Dual-Mode Ethernet Transmit PHY Interface

This block sits between a MAC-side byte stream and an external Ethernet transceiver. It accepts frame bytes through a valid/ready handshake and places them on a media-independent transmit interface. The interface has four data lines, an enable, an error line and a clock that the transceiver supplies. Before the first payload byte the block inserts a preamble of 0x55 octets and the start-of-frame delimiter 0xD5. It holds the enable high for exactly the symbols of the frame.

A configuration input picks one of two line formats, and the block samples it once per frame. With the input high, the block drives one 4-bit nibble per clock. With it low, it drives one bit per clock on data line 0, which suits 10 Mb/s serial transceivers. If the upstream source fails to supply a byte when the line needs one, the block keeps the frame running and pads it with zero octets. It also raises the error line until the frame ends.

Top module: `eth_tx_phy_if`

## Requirements
- R1: While reset is asserted, and in idle after reset, `txd_en`, `txd` and `txd_err` are 0 and `s_ready` is 0.
- R2: When `s_valid` is sampled high in idle at clock edge E, the enable and the first preamble symbol appear at edge E+1.
- R3: Every frame begins with 7 octets of 0x55 followed by one octet 0xD5, then the payload octets in the order accepted. Preamble symbols carry `txd_err` = 0.
- R4: With `cfg_nibble` = 1 at frame start, each octet takes two clocks: bits 3:0 first, then bits 7:4, on `txd[3:0]`.
- R5: With `cfg_nibble` = 0 at frame start, each octet takes eight clocks on `txd[0]`, least significant bit first, and `txd[3:1]` stay 0.
- R6: After the last symbol of the octet marked by `s_last`, `txd_en` is low at the very next clock edge.
- R7: Whenever `txd_en` is low, `txd` is 0 and `txd_err` is 0.
- R8: `s_ready` is high only in the cycle before the final symbol of the SFD or of a non-final payload octet is driven, which is the one cycle where the next octet is loaded.
- R9: `cfg_nibble` is sampled only when a frame starts. Changes during a frame do not alter that frame's format.
- R10: An octet accepted with `s_err` = 1 is driven with `txd_err` = 1 for all of its symbols. Neighbouring octets keep `txd_err` = 0.
- R11: If `s_valid` is low when `s_ready` is high, a 0x00 octet is inserted in that slot. `txd_err` is then 1 from that octet to the end of the frame, and later octets follow normally.
- R12: Between frames `txd_en` is low for at least one clock. A frame waiting while the previous one ends starts after exactly one low cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tx_clk | input | 1 | Free-running transmit clock from the transceiver |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_nibble | input | 1 | 1 = 4-bit nibble format, 0 = 1-bit serial format |
| s_valid | input | 1 | Upstream octet valid |
| s_ready | output | 1 | Block loads the offered octet at this edge |
| s_data | input | 8 | Upstream octet |
| s_last | input | 1 | Marks the final octet of the frame |
| s_err | input | 1 | Upstream flags this octet as bad |
| txd_en | output | 1 | Transmit enable |
| txd | output | 4 | Transmit data lines |
| txd_err | output | 1 | Transmit error |

## Verification
Several rules are checked by properties on every cycle: the lines stay quiet while the enable is low, the upper data lines stay clear in serial format, the format stays frozen while a frame is on the line, `s_ready` appears only inside an active frame, and an underrun error persists. The preamble and SFD content, the nibble and bit ordering, the exact clock of the enable edges, the error marking of a single octet, filler insertion and the one-cycle gap between back-to-back frames can only be shown by the scenarios. There, a scoreboard compares every driven symbol against a sequence built from the requirements.

// File: rtl/txphy_pkg.sv
package txphy_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  localparam logic [7:0] PRE_OCTET = 8'h55;
  localparam logic [7:0] SFD_OCTET = 8'hD5;
  localparam logic [7:0] PAD_OCTET = 8'h00;
endpackage

// File: rtl/txphy_ctrl.sv
module txphy_ctrl
  import txphy_pkg::*;
#(
  parameter int PRE_LEN = 7,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_nibble,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_err,
  input  logic              in_last,
  input  logic              byte_done,
  input  logic              cur_last,
  output logic              in_ready,
  output logic              mode_nib,
  output logic              underrun,
  output logic              start,
  output logic              emit,
  output logic              ld_en,
  output logic [BYTE_W-1:0] ld_byte,
  output logic              ld_err,
  output logic              ld_last
);
  localparam int CW = $clog2(PRE_LEN + 1);

  phase_e         ph_q, ph_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           mode_q, mode_d;
  logic           under_q, under_d;
  logic           need_pay;
  logic           pre_slot;

  assign mode_nib = mode_q;
  assign underrun = under_q;
  assign start    = (ph_q == PH_IDLE) && in_valid;
  assign emit     = (ph_q != PH_IDLE);
  assign pre_slot = (ph_q == PH_PRE) && (cnt_q != CW'(PRE_LEN));
  assign need_pay = byte_done && !pre_slot && !((ph_q == PH_DATA) && cur_last);
  assign in_ready = need_pay;

  always_comb begin
    ld_en   = byte_done && !((ph_q == PH_DATA) && cur_last);
    ld_byte = PRE_OCTET;
    ld_err  = 1'b0;
    ld_last = 1'b0;
    if (pre_slot) begin
      ld_byte = (cnt_q == CW'(PRE_LEN - 1)) ? SFD_OCTET : PRE_OCTET;
    end else if (in_valid) begin
      ld_byte = in_data;
      ld_err  = in_err | under_q;
      ld_last = in_last;
    end else begin
      ld_byte = PAD_OCTET;
      ld_err  = 1'b1;
    end
  end

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    mode_d  = mode_q;
    under_d = under_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d    = PH_PRE;
          cnt_d   = '0;
          mode_d  = cfg_nibble;
          under_d = 1'b0;
        end
      end
      PH_PRE: begin
        if (byte_done) begin
          if (pre_slot) cnt_d = cnt_q + CW'(1);
          else          ph_d  = PH_DATA;
        end
      end
      PH_DATA: begin
        if (byte_done && cur_last) ph_d = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
    if (need_pay && !in_valid) under_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      mode_q  <= 1'b1;
      under_q <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      mode_q  <= mode_d;
      under_q <= under_d;
    end
  end
endmodule

// File: rtl/txphy_ser.sv
module txphy_ser
  import txphy_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_nib,
  input  logic              start,
  input  logic              emit,
  input  logic              ld_en,
  input  logic [BYTE_W-1:0] ld_byte,
  input  logic              ld_err,
  input  logic              ld_last,
  output logic              byte_done,
  output logic              cur_last,
  output logic              tx_en,
  output logic [NIB_W-1:0]  tx_dat,
  output logic              tx_err
);
  localparam int PW      = $clog2(BYTE_W);
  localparam int NIB_PER = BYTE_W / NIB_W;

  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              berr_q, berr_d;
  logic              blast_q, blast_d;
  logic [PW-1:0]     pos_q, pos_d;
  logic [PW-1:0]     last_pos;
  logic              en_q, en_d;
  logic [NIB_W-1:0]  dat_q, dat_d;
  logic              err_q, err_d;
  logic [BYTE_W-1:0] shifted;
  logic [NIB_W-1:0]  sym;
  int unsigned       shamt;

  assign last_pos  = mode_nib ? PW'(NIB_PER - 1) : PW'(BYTE_W - 1);
  assign byte_done = emit && (pos_q == last_pos);
  assign cur_last  = blast_q;

  always_comb begin
    shamt   = mode_nib ? (32'(pos_q) * NIB_W) : 32'(pos_q);
    shifted = byte_q >> shamt;
    if (mode_nib) sym = shifted[NIB_W-1:0];
    else          sym = {{(NIB_W-1){1'b0}}, shifted[0]};
  end

  always_comb begin
    byte_d  = byte_q;
    berr_d  = berr_q;
    blast_d = blast_q;
    pos_d   = pos_q;
    en_d    = emit;
    dat_d   = emit ? sym : '0;
    err_d   = emit && berr_q;
    if (start) begin
      byte_d  = PRE_OCTET;
      berr_d  = 1'b0;
      blast_d = 1'b0;
      pos_d   = '0;
    end else if (emit) begin
      if (byte_done) begin
        pos_d = '0;
        if (ld_en) begin
          byte_d  = ld_byte;
          berr_d  = ld_err;
          blast_d = ld_last;
        end
      end else begin
        pos_d = pos_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q  <= '0;
      berr_q  <= 1'b0;
      blast_q <= 1'b0;
      pos_q   <= '0;
      en_q    <= 1'b0;
      dat_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      byte_q  <= byte_d;
      berr_q  <= berr_d;
      blast_q <= blast_d;
      pos_q   <= pos_d;
      en_q    <= en_d;
      dat_q   <= dat_d;
      err_q   <= err_d;
    end
  end

  assign tx_en  = en_q;
  assign tx_dat = dat_q;
  assign tx_err = err_q;
endmodule

// File: rtl/eth_tx_phy_if.sv
module eth_tx_phy_if #(
  parameter int PRE_LEN  = 7,
  parameter int BYTE_W   = 8,
  parameter int NIB_W    = 4,
  parameter int SYNC_LEN = 2
) (
  input  logic              tx_clk,
  input  logic              rst_n,
  input  logic              cfg_nibble,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_last,
  input  logic              s_err,
  output logic              txd_en,
  output logic [NIB_W-1:0]  txd,
  output logic              txd_err
);
  logic [SYNC_LEN-1:0] rst_pipe;
  logic                rst_sync_n;
  logic                mode_nib;
  logic                underrun;
  logic                start;
  logic                emit;
  logic                ld_en;
  logic [BYTE_W-1:0]   ld_byte;
  logic                ld_err;
  logic                ld_last;
  logic                byte_done;
  logic                cur_last;

  generate
    if (SYNC_LEN == 1) begin : g_sync1
      always_ff @(posedge tx_clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge tx_clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= {rst_pipe[SYNC_LEN-2:0], 1'b1};
      end
    end
  endgenerate
  assign rst_sync_n = rst_pipe[SYNC_LEN-1];

  txphy_ctrl #(.PRE_LEN(PRE_LEN), .BYTE_W(BYTE_W)) u_ctrl (
    .clk       (tx_clk),
    .rst_n     (rst_sync_n),
    .cfg_nibble(cfg_nibble),
    .in_valid  (s_valid),
    .in_data   (s_data),
    .in_err    (s_err),
    .in_last   (s_last),
    .byte_done (byte_done),
    .cur_last  (cur_last),
    .in_ready  (s_ready),
    .mode_nib  (mode_nib),
    .underrun  (underrun),
    .start     (start),
    .emit      (emit),
    .ld_en     (ld_en),
    .ld_byte   (ld_byte),
    .ld_err    (ld_err),
    .ld_last   (ld_last)
  );

  txphy_ser #(.BYTE_W(BYTE_W), .NIB_W(NIB_W)) u_ser (
    .clk      (tx_clk),
    .rst_n    (rst_sync_n),
    .mode_nib (mode_nib),
    .start    (start),
    .emit     (emit),
    .ld_en    (ld_en),
    .ld_byte  (ld_byte),
    .ld_err   (ld_err),
    .ld_last  (ld_last),
    .byte_done(byte_done),
    .cur_last (cur_last),
    .tx_en    (txd_en),
    .tx_dat   (txd),
    .tx_err   (txd_err)
  );
endmodule

// File: rtl/eth_tx_phy_if_chk.sv
module eth_tx_phy_if_chk #(
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_ready,
  input logic             txd_en,
  input logic [NIB_W-1:0] txd,
  input logic             txd_err,
  input logic             mode_nib,
  input logic             underrun
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !txd_en |-> (txd == '0) && !txd_err); // R7

  AST_SER_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_en && !mode_nib) |-> (txd[NIB_W-1:1] == '0)); // R5

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    txd_en |=> (!txd_en || $stable(mode_nib))); // R9

  AST_READY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> txd_en); // R8

  AST_READY_NEXT_SYM: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> txd_en); // R8

  AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && txd_en && txd_err) |=> (!txd_en || txd_err)); // R11
endmodule

bind eth_tx_phy_if eth_tx_phy_if_chk #(.NIB_W(NIB_W)) u_chk (
  .clk     (tx_clk),
  .rst_n   (rst_sync_n),
  .s_ready (s_ready),
  .txd_en  (txd_en),
  .txd     (txd),
  .txd_err (txd_err),
  .mode_nib(mode_nib),
  .underrun(underrun)
);

// File: tb/tb_eth_tx_phy_if.sv
`timescale 1ns/1ps
module tb_eth_tx_phy_if;
  typedef logic [7:0] bq_t[$];

  logic       clk;
  logic       rst_n;
  logic       cfg_nibble;
  logic       s_valid;
  logic       s_ready;
  logic [7:0] s_data;
  logic       s_last;
  logic       s_err;
  logic       txd_en;
  logic [3:0] txd;
  logic       txd_err;

  int total = 0;
  int bad   = 0;
  logic [5:0] exp_q[$];
  string      tag_q[$];
  bit         mon_on = 1'b0;
  int         exp_gap = -1;
  int         low_run = 0;
  logic       prev_en = 1'b0;

  eth_tx_phy_if dut (
    .tx_clk(clk), .rst_n(rst_n), .cfg_nibble(cfg_nibble),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_last(s_last), .s_err(s_err),
    .txd_en(txd_en), .txd(txd), .txd_err(txd_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic push_octet(input logic [7:0] b, input bit e, input bit m, input string tag);
    if (m) begin
      exp_q.push_back({1'b0, e, b[3:0]}); tag_q.push_back(tag);
      exp_q.push_back({1'b0, e, b[7:4]}); tag_q.push_back(tag);
    end else begin
      for (int i = 0; i < 8; i++) begin
        exp_q.push_back({1'b0, e, 3'b000, b[i]}); tag_q.push_back(tag);
      end
    end
  endtask

  task automatic wait_ready();
    bit done = 1'b0;
    while (!done) begin
      if (s_ready) begin
        @(posedge clk);
        @(negedge clk);
        done = 1'b1;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  task automatic send_frame(input bq_t bytes, input int err_idx, input int ur_idx,
                            input bit chk_start, input bit flip);
    bit m;
    bit sticky = 1'b0;
    m = cfg_nibble;
    for (int i = 0; i < 7; i++) push_octet(8'h55, 1'b0, m, "R3");
    push_octet(8'hD5, 1'b0, m, "R3");
    for (int i = 0; i < bytes.size(); i++) begin
      if (i == ur_idx) begin
        push_octet(8'h00, 1'b1, m, "R11");
        sticky = 1'b1;
      end
      push_octet(bytes[i], sticky || (i == err_idx), m,
                 sticky ? "R11" : ((i == err_idx) ? "R10" : (m ? "R4" : "R5")));
    end
    exp_q.push_back(6'b100000); tag_q.push_back("R6");

    @(negedge clk);
    for (int i = 0; i < bytes.size(); i++) begin
      if (i == ur_idx) begin
        s_valid = 1'b0;
        wait_ready();
      end
      s_valid = 1'b1;
      s_data  = bytes[i];
      s_last  = (i == bytes.size() - 1);
      s_err   = (i == err_idx);
      if (i == 0 && chk_start) begin
        @(posedge clk);
        @(negedge clk);
        check(txd_en == 1'b0, "R2", $sformatf("enable early got=%0d exp=0", txd_en));
        @(posedge clk);
        @(negedge clk);
        check(txd_en == 1'b1, "R2", $sformatf("enable late got=%0d exp=1", txd_en));
        if (flip) cfg_nibble = ~cfg_nibble;
      end
      wait_ready();
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
    s_err   = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (txd_en) begin
        if (!prev_en && exp_gap >= 0) begin
          check(low_run == exp_gap, "R12",
                $sformatf("idle gap got=%0d exp=%0d", low_run, exp_gap));
          exp_gap = -1;
        end
        if (exp_q.size() == 0) begin
          check(1'b0, "R6", "enable high with nothing expected got en=1 exp en=0");
        end else begin
          logic [5:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (e[5]) begin
            check(1'b0, "R6", "enable still high after frame end got en=1 exp en=0");
          end else begin
            check(txd == e[3:0] && txd_err == e[4], t,
                  $sformatf("got dat=%h err=%0d exp dat=%h err=%0d",
                            txd, txd_err, e[3:0], e[4]));
          end
        end
        low_run = 0;
      end else begin
        if (txd != 4'h0 || txd_err != 1'b0)
          check(1'b0, "R7", $sformatf("idle lines got dat=%h err=%0d exp dat=0 err=0",
                                      txd, txd_err));
        if (prev_en) begin
          if (exp_q.size() != 0 && exp_q[0][5]) begin
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
            check(1'b1, "R6", "");
          end else begin
            check(1'b0, "R6", $sformatf("enable fell early, %0d symbols still expected",
                                        exp_q.size()));
          end
        end
        low_run++;
      end
      prev_en = txd_en;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run hung, got timeout exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_nibble = 1'b1; s_valid = 1'b0;
    s_data = 8'h00; s_last = 1'b0; s_err = 1'b0;
    repeat (3) @(negedge clk);
    check(txd_en == 0 && txd == 0 && txd_err == 0 && s_ready == 0, "R1",
          $sformatf("in reset got en=%0d dat=%h err=%0d rdy=%0d exp 0 0 0 0",
                    txd_en, txd, txd_err, s_ready));
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(txd_en == 0 && txd == 0 && txd_err == 0 && s_ready == 0, "R1",
          $sformatf("idle got en=%0d dat=%h err=%0d rdy=%0d exp 0 0 0 0",
                    txd_en, txd, txd_err, s_ready));
    mon_on = 1'b1;

    // R4: nibble format, low nibble first
    cfg_nibble = 1'b1;
    send_frame('{8'h3C, 8'hA5, 8'h0F, 8'h81}, -1, -1, 1'b1, 1'b0);
    wait_idle();
    // R5: serial format, LSB first
    cfg_nibble = 1'b0;
    send_frame('{8'h96, 8'h01, 8'h80}, -1, -1, 1'b1, 1'b0);
    wait_idle();
    // R10: one octet flagged bad, nibble format
    cfg_nibble = 1'b1;
    send_frame('{8'h12, 8'hE7, 8'h34, 8'h56, 8'h78}, 1, -1, 1'b1, 1'b0);
    wait_idle();
    // R11: underrun in serial format
    cfg_nibble = 1'b0;
    send_frame('{8'hC3, 8'h5A, 8'h7E, 8'h11}, -1, 2, 1'b1, 1'b0);
    wait_idle();
    // R11: underrun right after the first payload octet, nibble format
    cfg_nibble = 1'b1;
    send_frame('{8'h9B, 8'h42, 8'hF0}, -1, 1, 1'b1, 1'b0);
    wait_idle();
    // R9: format input toggled mid-frame, frame stays serial
    cfg_nibble = 1'b0;
    send_frame('{8'hB4, 8'h6D, 8'h2F}, -1, -1, 1'b1, 1'b1);
    wait_idle();
    // R9: the new value applies to the next frame (nibble now)
    send_frame('{8'hE1, 8'h07}, -1, -1, 1'b1, 1'b0);
    wait_idle();
    // R6: single-octet frame
    cfg_nibble = 1'b1;
    send_frame('{8'hA9}, -1, -1, 1'b1, 1'b0);
    wait_idle();
    // R12: back-to-back frames, nibble format
    cfg_nibble = 1'b1;
    send_frame('{8'h21, 8'h43}, -1, -1, 1'b1, 1'b0);
    exp_gap = 1;
    send_frame('{8'h65, 8'h87, 8'hCB}, -1, -1, 1'b0, 1'b0);
    wait_idle();
    // R12: back-to-back frames, serial format
    cfg_nibble = 1'b0;
    send_frame('{8'hD2}, -1, -1, 1'b1, 1'b0);
    exp_gap = 1;
    send_frame('{8'h3E, 8'h70}, -1, -1, 1'b0, 1'b0);
    wait_idle();

    check(exp_q.size() == 0, "R6", $sformatf("leftover items got=%0d exp=0", exp_q.size()));
    check(txd_en == 0 && s_ready == 0, "R1",
          $sformatf("final idle got en=%0d rdy=%0d exp 0 0", txd_en, s_ready));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule